// File: doc/BRIEF.md
# Input Pass-FET Supervisor

This block decides when the input pass-FET between the adapter and the current-limit node may conduct, and how it is turned off. It works from comparator flags that quantize the voltage difference from the adapter input to the current-limit node into four bands: below -25 mV, -25 mV to +25 mV, +25 mV to +170 mV, and above +170 mV. It also takes an external shutdown request. It drives a gate enable, a turn-off speed select for the analog gate driver, an adapter-present indicator and a charger enable.

The FET is armed only when the difference clears +170 mV. A drop below +25 mV turns the FET off at the slow rate and leaves the adapter indicator high. A reverse difference below -25 mV removes the gate at once through a combinational path from the synchronized flag, selects the fast turn-off rate, pulls the indicator low and disables charging. That fast state is latched. Every turn-off needs a fresh +170 mV indication before the FET conducts again. All four inputs are asynchronous and pass through a synchronizer of `SYNC_STAGES` flops. The default is 2.

Top module: `infet_guard`

## Requirements
- R1: While `rst_n` is low, after a rising clock edge all four outputs are 0 and the supervisor is in the off state.
- R2: With `dif_arm_i`=1 and `dif_low_i`=`dif_rev_i`=0, a supervisor that is not conducting turns the gate on (`gate_on_o`=1, `adp_ok_o`=1) on the third rising edge after the flags are applied (two synchronizer edges plus one state edge).
- R3: While the difference stays in the +25 mV to +170 mV band (all three flags 0), a non-conducting supervisor keeps `gate_on_o`=0 indefinitely.
- R4: While conducting, `dif_low_i`=1 with `dif_rev_i`=0 turns the gate off on the third rising edge with `fast_off_o`=0 (slow rate) and `adp_ok_o` held at 1.
- R5: `dif_rev_i`=1 forces `gate_on_o`=0, `fast_off_o`=1, `adp_ok_o`=0 and `chg_en_o`=0 after the second rising edge, without waiting for a state update, from any state.
- R6: After a reverse trip, the outputs stay at `gate_on_o`=0, `fast_off_o`=1 and `adp_ok_o`=0 once `dif_rev_i` clears, until an arming indication arrives.
- R7: After any turn-off, slow or fast, the FET conducts again only after `dif_arm_i` is seen. The band from +25 mV to +170 mV alone never re-arms it.
- R8: `shdn_i`=1 forces `chg_en_o`=0 after the second rising edge and leaves `gate_on_o` unchanged. Releasing it restores `chg_en_o` while conducting.
- R9: `chg_en_o` is 1 only while `gate_on_o` is 1 and shutdown is not requested.
- R10: When flags conflict, reverse has priority over low, and low has priority over arm. For example, `dif_arm_i`=`dif_rev_i`=1 produces the fast-trip outputs of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dif_arm_i | input | 1 | Difference above +170 mV (asynchronous) |
| dif_low_i | input | 1 | Difference below +25 mV (asynchronous) |
| dif_rev_i | input | 1 | Difference below -25 mV (asynchronous) |
| shdn_i | input | 1 | External shutdown request (asynchronous) |
| gate_on_o | output | 1 | Pass-FET gate enable |
| fast_off_o | output | 1 | Turn-off speed select: 1 fast, 0 slow |
| adp_ok_o | output | 1 | Adapter-present indicator |
| chg_en_o | output | 1 | Charger enable |

## Verification
A wrong state register shows up at the ports one edge after the bad transition, as a gate that conducts without an arming flag or an indicator that disagrees with the speed select. Damage in the fast-trip path shows up two edges after a reverse flag, as a gate still high or an indicator still high. Damage in the latching of the fast state shows up as soon as the reverse flag clears without an arming flag present. The bench compares every output on every cycle against a band-level model, so a divergence is reported in the cycle it first appears.

// File: rtl/infet_guard_pkg.sv
// Shared types for the input pass-FET supervisor.
// Assumes: flag vector bit positions are fixed by the localparams below.
package infet_guard_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,   // never armed since reset
        ST_ON   = 2'd1,   // FET conducting
        ST_SLOW = 2'd2,   // turned off at slow rate, adapter still present
        ST_FAST = 2'd3    // tripped on reverse difference
    } fet_state_t;

    localparam int FLAG_W = 4;
    localparam int F_ARM  = 0;
    localparam int F_LOW  = 1;
    localparam int F_REV  = 2;
    localparam int F_SHDN = 3;

endpackage

// File: rtl/ig_sync.sv
// Multi-bit flop chain that brings asynchronous, independent flags into
// the clock domain. Assumes each bit is a level that is stable for longer
// than STAGES clocks, so the bits need no mutual coherence.
module ig_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] pipe;

    // Shift the raw flags through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/ig_fsm.sv
// State register for the pass-FET supervisor. It moves to the fast state on
// a reverse flag from any state, leaves conduction for the slow state on a
// low flag, and arms only on an arming flag that is not contradicted.
// Assumes: inputs are already synchronized.
module ig_fsm
    import infet_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm_s,
    input  logic       low_s,
    input  logic       rev_s,
    output fet_state_t state
);

    fet_state_t nxt;

    // Next-state selection with priority reverse > low > arm.
    always_comb begin
        nxt = state;
        if (rev_s) begin
            nxt = ST_FAST;
        end else if (state == ST_ON) begin
            if (low_s) nxt = ST_SLOW;
        end else if (arm_s && !low_s) begin
            nxt = ST_ON;
        end
    end

    // State register with synchronous reset to off.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

endmodule

// File: rtl/ig_drive.sv
// Output decode. The reverse flag overrides the registered state
// combinationally, so the gate drops without waiting for a state edge.
// Assumes: rev_s and shdn_s come from the synchronizer.
module ig_drive
    import infet_guard_pkg::*;
(
    input  fet_state_t state,
    input  logic       rev_s,
    input  logic       shdn_s,
    output logic       gate_on,
    output logic       fast_off,
    output logic       adp_ok,
    output logic       chg_en
);

    // Map state and override flags onto the four outputs.
    always_comb begin
        gate_on  = (state == ST_ON) && !rev_s;
        fast_off = (state == ST_FAST) || rev_s;
        adp_ok   = ((state == ST_ON) || (state == ST_SLOW)) && !rev_s;
        chg_en   = gate_on && !shdn_s;
    end

endmodule

// File: rtl/infet_guard.sv
// Top of the input pass-FET supervisor: synchronizer, state register and
// output decode. Assumes the comparator flags are levels from the analog
// front end and that the gate driver interprets fast_off_o as the rate.
module infet_guard
    import infet_guard_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dif_arm_i,
    input  logic dif_low_i,
    input  logic dif_rev_i,
    input  logic shdn_i,
    output logic gate_on_o,
    output logic fast_off_o,
    output logic adp_ok_o,
    output logic chg_en_o
);

    logic [FLAG_W-1:0] raw_flags;
    logic [FLAG_W-1:0] syn_flags;
    logic              arm_s;
    logic              low_s;
    logic              rev_s;
    logic              shdn_s;
    fet_state_t        state;

    // Pack the asynchronous flags into one vector.
    always_comb begin
        raw_flags         = '0;
        raw_flags[F_ARM]  = dif_arm_i;
        raw_flags[F_LOW]  = dif_low_i;
        raw_flags[F_REV]  = dif_rev_i;
        raw_flags[F_SHDN] = shdn_i;
    end

    ig_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_flags),
        .q     (syn_flags)
    );

    assign arm_s  = syn_flags[F_ARM];
    assign low_s  = syn_flags[F_LOW];
    assign rev_s  = syn_flags[F_REV];
    assign shdn_s = syn_flags[F_SHDN];

    ig_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .arm_s (arm_s),
        .low_s (low_s),
        .rev_s (rev_s),
        .state (state)
    );

    ig_drive u_drive (
        .state    (state),
        .rev_s    (rev_s),
        .shdn_s   (shdn_s),
        .gate_on  (gate_on_o),
        .fast_off (fast_off_o),
        .adp_ok   (adp_ok_o),
        .chg_en   (chg_en_o)
    );

endmodule

// File: rtl/infet_guard_chk.sv
// Property checker for infet_guard, attached by bind. It relates the
// synchronized flags to the outputs over time.
module infet_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic arm_s,
    input logic low_s,
    input logic rev_s,
    input logic shdn_s,
    input logic gate_on_o,
    input logic fast_off_o,
    input logic adp_ok_o,
    input logic chg_en_o
);

    // R5
    rev_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rev_s |-> (!gate_on_o && fast_off_o && !adp_ok_o && !chg_en_o));

    // R4
    slow_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_on_o && low_s && !rev_s) |=> !gate_on_o);

    // R6
    fast_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_off_o && !arm_s) |=> fast_off_o);

    // R7
    rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_on_o) |-> $past(arm_s));

    // R8
    shdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_s |-> !chg_en_o);

    // R9
    chg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_en_o |-> gate_on_o);

endmodule

bind infet_guard infet_guard_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_s      (arm_s),
    .low_s      (low_s),
    .rev_s      (rev_s),
    .shdn_s     (shdn_s),
    .gate_on_o  (gate_on_o),
    .fast_off_o (fast_off_o),
    .adp_ok_o   (adp_ok_o),
    .chg_en_o   (chg_en_o)
);

// File: tb/infet_guard_tb.sv
`timescale 1ns/1ps
module infet_guard_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm = 1'b0, low = 1'b0, rev = 1'b0, shdn = 1'b0;
    logic gate_on, fast_off, adp_ok, chg_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    infet_guard u_dut (
        .clk (clk), .rst_n (rst_n),
        .dif_arm_i (arm), .dif_low_i (low), .dif_rev_i (rev), .shdn_i (shdn),
        .gate_on_o (gate_on), .fast_off_o (fast_off),
        .adp_ok_o (adp_ok), .chg_en_o (chg_en)
    );

    // Band-level reference: 0 <-25mV, 1 -25..25, 2 25..170, 3 >170
    // model state: 0 off, 1 on, 2 slow, 3 fast
    logic [3:0] m_p1, m_p2;   // {shdn, rev, low, arm}
    int m_st;

    function automatic int next_st(int st, logic [3:0] f);
        if (f[2]) return 3;
        if (st == 1) return f[1] ? 2 : 1;
        if (f[0] && !f[1]) return 1;
        return st;
    endfunction

    function automatic logic [3:0] exp_out(int st, logic [3:0] f);
        logic g, fo, a, c;
        g  = (st == 1) && !f[2];
        fo = (st == 3) || f[2];
        a  = (st == 1 || st == 2) && !f[2];
        c  = g && !f[3];
        return {g, fo, a, c};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_p1 <= '0; m_p2 <= '0; m_st <= 0;
        end else begin
            m_p1 <= {shdn, rev, low, arm};
            m_p2 <= m_p1;
            m_st <= next_st(m_st, m_p2);
        end
    end

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic set_lvl(int lvl);
        arm = (lvl == 3);
        low = (lvl <= 1);
        rev = (lvl == 0);
    endtask

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cmp_model(string tag);
        logic [3:0] e;
        e = exp_out(m_st, m_p2);
        chk({tag, " gate R2"},  gate_on,  e[3]);
        chk({tag, " fast R5"},  fast_off, e[2]);
        chk({tag, " adp R4"},   adp_ok,   e[1]);
        chk({tag, " chg R9"},   chg_en,   e[0]);
    endtask

    initial begin
        @(negedge clk);
        set_lvl(3);
        edges(3);
        // R1: outputs idle while reset is held, even with arm applied
        chk("R1 gate", gate_on, 1'b0);
        chk("R1 fast", fast_off, 1'b0);
        chk("R1 adp", adp_ok, 1'b0);
        chk("R1 chg", chg_en, 1'b0);
        set_lvl(2);
        rst_n = 1'b1;
        edges(6);
        chk("R3 no arm in mid band", gate_on, 1'b0);

        set_lvl(3);
        edges(2);
        chk("R2 not yet on", gate_on, 1'b0);
        edges(1);
        chk("R2 gate on", gate_on, 1'b1);
        chk("R2 adp high", adp_ok, 1'b1);
        chk("R9 chg on", chg_en, 1'b1);

        shdn = 1'b1;
        edges(2);
        chk("R8 chg off", chg_en, 1'b0);
        chk("R8 gate kept", gate_on, 1'b1);
        shdn = 1'b0;
        edges(2);
        chk("R8 chg back", chg_en, 1'b1);

        set_lvl(1);
        edges(3);
        chk("R4 gate off", gate_on, 1'b0);
        chk("R4 slow rate", fast_off, 1'b0);
        chk("R4 adp kept", adp_ok, 1'b1);
        chk("R9 chg off", chg_en, 1'b0);

        set_lvl(2);
        edges(5);
        chk("R7 no rearm after slow", gate_on, 1'b0);

        set_lvl(3);
        edges(3);
        chk("R7 rearm", gate_on, 1'b1);

        set_lvl(0);
        edges(1);
        chk("R5 before sync", gate_on, 1'b1);
        edges(1);
        chk("R5 gate off", gate_on, 1'b0);
        chk("R5 fast rate", fast_off, 1'b1);
        chk("R5 adp low", adp_ok, 1'b0);
        chk("R5 chg off", chg_en, 1'b0);

        set_lvl(2);
        edges(5);
        chk("R6 fast latched", fast_off, 1'b1);
        chk("R6 adp low", adp_ok, 1'b0);
        chk("R7 no rearm after fast", gate_on, 1'b0);

        set_lvl(3);
        edges(3);
        chk("R7 rearm after fast", gate_on, 1'b1);
        chk("R6 fast cleared", fast_off, 1'b0);

        // R10: conflicting arm and reverse flags
        arm = 1'b1; low = 1'b0; rev = 1'b1;
        edges(2);
        chk("R10 rev wins gate", gate_on, 1'b0);
        chk("R10 rev wins fast", fast_off, 1'b1);
        // R10: arm with low from fast state does not arm
        arm = 1'b1; low = 1'b1; rev = 1'b0;
        edges(4);
        chk("R10 low beats arm", gate_on, 1'b0);

        // Randomized bands with held durations, checked every cycle
        void'($urandom(32'd1234));
        for (int blk = 0; blk < 400; blk++) begin
            int lvl = $urandom_range(0, 3);
            int hold = $urandom_range(1, 8);
            set_lvl(lvl);
            shdn = ($urandom_range(0, 3) == 0);
            for (int c = 0; c < hold; c++) begin
                edges(1);
                cmp_model("rand");
            end
        end

        // Mid-run reset returns to idle (R1)
        rst_n = 1'b0;
        edges(1);
        chk("R1 reset gate", gate_on, 1'b0);
        chk("R1 reset fast", fast_off, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule